// File: doc/BRIEF.md
# Reset Cause Capture Register

This block collects every request that can reset the system and drives one combined active-low reset output. The request lines come from a power-on detector, the external reset pin, a watchdog timeout, an illegal-opcode detector, a clock-loss monitor and a low-voltage monitor. A debugger can also force a reset with a one-cycle strobe. Each of these requests is modelled as a simple input pulse. The block does not contain the detectors, the watchdog counter or the opcode decoder.

Once a reset sequence starts, the block keeps sampling the request lines until the reset output is released. On the clock edge that releases reset, it loads the set of sources seen during that reset into an 8-bit read-only status byte. Firmware reads this byte through a one-address register bus. A write to that address does not change the status. Instead, the write strobe is passed out as the watchdog service pulse. The bus has no write-data lines because the written value is never used.

The power-on input is asynchronous and clears the whole block. Every other source is a synchronous request that goes into the same hold counter.

Top module: `rstcause_top`

## Requirements
- R1: The status byte is laid out as follows: power-on at bit 7, external pin at bit 6, watchdog timeout at bit 5, illegal opcode at bit 4, clock loss at bit 2 and low voltage at bit 1. Bits 3 and 0 always read 0. When `bus_sel` and `bus_rd` are both high, `bus_rdata` shows the status in the same cycle; otherwise `bus_rdata` is 0.
- R2: On each release of reset, the status is replaced as a whole. A flag is set if its source was active in any cycle of that reset, and cleared if it was not.
- R3: `por_n` low resets the block asynchronously and holds `sys_rst_n` low. The status after a power-on reset has both bit 7 and bit 1 set (0x82 when no other source was active).
- R4: If `dbg_req` was high in any cycle of a reset, the status after that reset is 0x00, whatever else was active.
- R5: A cycle with `bus_sel` and `bus_wr` high drives `wdog_clr` high in that same cycle and leaves the status unchanged. `wdog_clr` is low in every other cycle.
- R6: `wdog_req` starts a reset and sets bit 5 only when `wdog_en` is 1. When `wdog_en` is 0, `wdog_req` has no effect.
- R7: The illegal-opcode request (bit 4) is raised by `illop_req`. It is also raised by `stop_try` while `stop_en` is 0, and by `bkgd_try` while `bkgd_en` is 0. `stop_try` with `stop_en` at 1 is ignored, and so is `bkgd_try` with `bkgd_en` at 1.
- R8: `sys_rst_n` goes low in the cycle after a request is sampled. It stays low for exactly 8 cycles after the last cycle in which a request was active. The status changes only on the edge that releases reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_req | input | 1 | External pin reset request |
| wdog_req | input | 1 | Watchdog timeout request |
| wdog_en | input | 1 | Watchdog reset enable |
| illop_req | input | 1 | Illegal opcode request |
| stop_try | input | 1 | Stop-mode entry attempt |
| stop_en | input | 1 | Stop mode permitted |
| bkgd_try | input | 1 | Background-debug entry attempt |
| bkgd_en | input | 1 | Background debug permitted |
| clkloss_req | input | 1 | Clock-loss reset request |
| lvr_req | input | 1 | Low-voltage reset request |
| dbg_req | input | 1 | Debugger forced-reset strobe |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (status byte) |
| wdog_clr | output | 1 | Watchdog service pulse |
| sys_rst_n | output | 1 | Combined system reset, active low |

## Verification
A bus access and a status transfer can fall in the same cycle. The bench provokes this by issuing a combined write and read in the last low cycle of a reset, the cycle before the release edge.

Three results are expected from that cycle:
- The read returns the old status.
- The watchdog pulse still appears.
- The status read one cycle later holds exactly the new cause.

Random request patterns with random enables are mixed with these directed cases. The expected byte and the expected start of reset are computed in bench functions.

// File: rtl/rstcause_pkg.sv
// Shared constants for the reset cause capture block.
// Assumes an 8-bit status byte with fixed flag positions that firmware decodes.
package rstcause_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_POR  = 7;
    localparam int BIT_PIN  = 6;
    localparam int BIT_WDT  = 5;
    localparam int BIT_ILL  = 4;
    localparam int BIT_CLK  = 2;
    localparam int BIT_LVR  = 1;
    localparam logic [STAT_W-1:0] RSVD_MASK = 8'h09;
    localparam logic [STAT_W-1:0] POR_VALUE = 8'h82;
endpackage

// File: rtl/rstcause_srcmap.sv
// Maps raw request lines onto status bit positions, applying the enables.
// Assumes all requests are synchronous to clk; power-on is handled elsewhere.
module rstcause_srcmap
    import rstcause_pkg::*;
(
    input  logic              ext_req,
    input  logic              wdog_req,
    input  logic              wdog_en,
    input  logic              illop_req,
    input  logic              stop_try,
    input  logic              stop_en,
    input  logic              bkgd_try,
    input  logic              bkgd_en,
    input  logic              clkloss_req,
    input  logic              lvr_req,
    output logic [STAT_W-1:0] req_vec
);
    // Build the per-cycle request vector in status-bit order.
    always_comb begin
        req_vec          = '0;
        req_vec[BIT_PIN] = ext_req;
        req_vec[BIT_WDT] = wdog_req & wdog_en;
        req_vec[BIT_ILL] = illop_req | (stop_try & ~stop_en) | (bkgd_try & ~bkgd_en);
        req_vec[BIT_CLK] = clkloss_req;
        req_vec[BIT_LVR] = lvr_req;
    end
endmodule

// File: rtl/rstcause_seq.sv
// Reset sequencer: stretches any request to HOLD cycles, accumulates the
// sources seen during the reset and flags the release cycle for loading.
// Assumes por_n is the only asynchronous reset in the block.
module rstcause_seq
    import rstcause_pkg::*;
#(
    parameter int HOLD = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [STAT_W-1:0] req_vec,
    input  logic              dbg_req,
    output logic              rst_n,
    output logic              load_en,
    output logic [STAT_W-1:0] load_val
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0]     cnt_q;
    logic [STAT_W-1:0] acc_q;
    logic              dbg_q;
    logic              req_any;
    logic              idle;

    assign req_any = (|req_vec) | dbg_req;
    assign idle    = (cnt_q == '0);

    // Hold counter and source accumulation across one reset sequence.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= CW'(HOLD);
            acc_q <= POR_VALUE;
            dbg_q <= 1'b0;
        end else begin
            if (req_any)
                cnt_q <= CW'(HOLD);
            else if (!idle)
                cnt_q <= cnt_q - CW'(1);
            acc_q <= (idle ? '0 : acc_q) | req_vec;
            dbg_q <= (idle ? 1'b0 : dbg_q) | dbg_req;
        end
    end

    // Release happens on the edge that takes the counter from 1 to 0.
    assign rst_n    = idle;
    assign load_en  = (cnt_q == CW'(1)) && !req_any;
    assign load_val = dbg_q ? '0 : (acc_q & ~RSVD_MASK);
endmodule

// File: rtl/rstcause_regif.sv
// Status register and single-address bus port. Writes only produce the
// watchdog service pulse; reads are combinational from the register.
module rstcause_regif
    import rstcause_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              load_en,
    input  logic [STAT_W-1:0] load_val,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              wdog_clr
);
    logic [STAT_W-1:0] stat_q;

    // Capture the cause set on the reset release edge only.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            stat_q <= POR_VALUE;
        else if (load_en)
            stat_q <= load_val;
    end

    // Same-cycle read data and watchdog service pulse.
    assign status    = stat_q;
    assign bus_rdata = (bus_sel && bus_rd) ? (stat_q & ~RSVD_MASK) : '0;
    assign wdog_clr  = bus_sel & bus_wr;
endmodule

// File: rtl/rstcause_top.sv
// Top of the reset cause capture block: request mapping, reset sequencer
// and status register. Assumes all requests are synchronous pulses.
module rstcause_top
    import rstcause_pkg::*;
#(
    parameter int HOLD = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_req,
    input  logic              wdog_req,
    input  logic              wdog_en,
    input  logic              illop_req,
    input  logic              stop_try,
    input  logic              stop_en,
    input  logic              bkgd_try,
    input  logic              bkgd_en,
    input  logic              clkloss_req,
    input  logic              lvr_req,
    input  logic              dbg_req,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              wdog_clr,
    output logic              sys_rst_n
);
    logic [STAT_W-1:0] req_vec;
    logic              load_en;
    logic [STAT_W-1:0] load_val;
    logic [STAT_W-1:0] status_q;

    rstcause_srcmap u_srcmap (
        .ext_req(ext_req), .wdog_req(wdog_req), .wdog_en(wdog_en),
        .illop_req(illop_req), .stop_try(stop_try), .stop_en(stop_en),
        .bkgd_try(bkgd_try), .bkgd_en(bkgd_en), .clkloss_req(clkloss_req),
        .lvr_req(lvr_req), .req_vec(req_vec)
    );

    rstcause_seq #(.HOLD(HOLD)) u_seq (
        .clk(clk), .por_n(por_n), .req_vec(req_vec), .dbg_req(dbg_req),
        .rst_n(sys_rst_n), .load_en(load_en), .load_val(load_val)
    );

    rstcause_regif u_regif (
        .clk(clk), .por_n(por_n), .load_en(load_en), .load_val(load_val),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .status(status_q), .bus_rdata(bus_rdata), .wdog_clr(wdog_clr)
    );
endmodule

// File: rtl/rstcause_chk.sv
// Property checker for rstcause_top, attached with bind below.
module rstcause_chk (
    input logic       clk,
    input logic       por_n,
    input logic       sys_rst_n,
    input logic [7:0] status_q,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       wdog_clr,
    input logic       ext_req,
    input logic       clkloss_req,
    input logic       lvr_req,
    input logic       dbg_req
);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_rd) |-> (bus_rdata[3] == 1'b0 && bus_rdata[0] == 1'b0));

    // R1
    read_same_cycle_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_rd) |-> (bus_rdata == (status_q & 8'hF6)));

    // R5
    wclr_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr) |-> wdog_clr);

    // R5
    write_keeps_status_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr && sys_rst_n) |=> $stable(status_q));

    // R3
    por_lvr_pair_chk: assert property (@(posedge clk) disable iff (!por_n)
        status_q[7] |-> status_q[1]);

    // R8
    req_asserts_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ext_req || clkloss_req || lvr_req || dbg_req) |=> !sys_rst_n);

    // R8
    status_only_at_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_n |=> $stable(status_q));
endmodule

bind rstcause_top rstcause_chk u_chk (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .status_q(status_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .wdog_clr(wdog_clr), .ext_req(ext_req), .clkloss_req(clkloss_req),
    .lvr_req(lvr_req), .dbg_req(dbg_req)
);

// File: tb/test_rstcause_top.sv
`timescale 1ns/1ps
module test_rstcause_top;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_req = 0, wdog_req = 0, wdog_en = 0, illop_req = 0;
    logic stop_try = 0, stop_en = 0, bkgd_try = 0, bkgd_en = 0;
    logic clkloss_req = 0, lvr_req = 0, dbg_req = 0;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_rdata;
    logic wdog_clr, sys_rst_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rstcause_top #(.HOLD(HOLD)) i_rstcause_top (
        .clk(clk), .por_n(por_n), .ext_req(ext_req), .wdog_req(wdog_req),
        .wdog_en(wdog_en), .illop_req(illop_req), .stop_try(stop_try),
        .stop_en(stop_en), .bkgd_try(bkgd_try), .bkgd_en(bkgd_en),
        .clkloss_req(clkloss_req), .lvr_req(lvr_req), .dbg_req(dbg_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .wdog_clr(wdog_clr), .sys_rst_n(sys_rst_n)
    );

    // Stimulus word bits: 0 ext, 1 wdog, 2 wdog_en, 3 illop, 4 stop_try,
    // 5 stop_en, 6 bkgd_try, 7 bkgd_en, 8 clkloss, 9 lvr, 10 dbg.
    function automatic logic [7:0] exp_vec(input logic [10:0] s);
        logic [7:0] v = 8'h00;
        v[6] = s[0];
        v[5] = s[1] & s[2];
        v[4] = s[3] | (s[4] & ~s[5]) | (s[6] & ~s[7]);
        v[2] = s[8];
        v[1] = s[9];
        return v;
    endfunction

    function automatic logic exp_any(input logic [10:0] s);
        return (|exp_vec(s)) | s[10];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [10:0] s);
        ext_req = s[0]; wdog_req = s[1]; wdog_en = s[2]; illop_req = s[3];
        stop_try = s[4]; stop_en = s[5]; bkgd_try = s[6]; bkgd_en = s[7];
        clkloss_req = s[8]; lvr_req = s[9]; dbg_req = s[10];
    endtask

    // Present s for one cycle; returns at the negedge after the sampling edge.
    task automatic apply(input logic [10:0] s);
        @(negedge clk);
        drive(s);
        @(negedge clk);
        drive(11'h0);
    endtask

    task automatic wait_release(output int lows);
        lows = 0;
        while (!sys_rst_n) begin
            lows++;
            @(negedge clk);
        end
    endtask

    task automatic read_stat(output logic [7:0] v);
        bus_sel = 1; bus_rd = 1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    // One full reset sequence with checks on hold length and result.
    task automatic run_reset(input string req, input logic [10:0] s);
        int lows;
        logic [7:0] v;
        apply(s);
        wait_release(lows);
        chk({req, " hold R8"}, 8'(lows), 8'(HOLD));
        read_stat(v);
        chk(req, v, s[10] ? 8'h00 : exp_vec(s));
    endtask

    initial begin
        int lows;
        logic [7:0] v, prev;
        logic [10:0] s;
        void'($urandom(32'h5EED_0042));

        // R3: power-on holds reset and presets the POR value
        #9;
        chk("R3 rst during por", {7'h0, sys_rst_n}, 8'h00);
        bus_sel = 1; bus_rd = 1; #1;
        chk("R3 status during por", bus_rdata, 8'h82);
        bus_sel = 0; bus_rd = 0;
        @(negedge clk);
        por_n = 1;
        wait_release(lows);
        chk("R8 hold after por", 8'(lows), 8'(HOLD));
        read_stat(v);
        chk("R3 por result", v, 8'h82);

        // R1: no read strobe gives zero
        bus_sel = 1; #1;
        chk("R1 no strobe", bus_rdata, 8'h00);
        bus_sel = 0; bus_rd = 1; #1;
        chk("R1 no select", bus_rdata, 8'h00);
        bus_rd = 0;

        // R2 R1 single sources
        run_reset("R1 R2 ext", 11'h001);
        run_reset("R6 wdog enabled", 11'h006);
        run_reset("R7 illop", 11'h008);
        run_reset("R7 stop while disabled", 11'h010);
        run_reset("R7 bkgd while disabled", 11'h040);
        run_reset("R1 clkloss", 11'h100);
        run_reset("R1 lvr", 11'h200);
        run_reset("R4 debug", 11'h400);
        run_reset("R4 debug with ext", 11'h501);

        // R6 R7: requests that must be ignored
        run_reset("R2 setup", 11'h100);
        apply(11'h002);
        chk("R6 wdog disabled no reset", {7'h0, sys_rst_n}, 8'h01);
        apply(11'h030);
        chk("R7 stop allowed no reset", {7'h0, sys_rst_n}, 8'h01);
        apply(11'h0C0);
        chk("R7 bkgd allowed no reset", {7'h0, sys_rst_n}, 8'h01);
        read_stat(v);
        chk("R6 R7 status kept", v, 8'h04);

        // R2 R8: sources across one reset accumulate; hold restarts
        apply(11'h001);
        repeat (3) @(negedge clk);
        drive(11'h100);
        @(negedge clk);
        drive(11'h0);
        wait_release(lows);
        chk("R8 hold from last request", 8'(lows), 8'(HOLD));
        read_stat(v);
        chk("R2 accumulate", v, 8'h44);
        run_reset("R2 stale cleared", 11'h200);

        // R5: write pulses service output, status unchanged
        bus_sel = 1; bus_wr = 1; #1;
        chk("R5 wdog_clr pulse", {7'h0, wdog_clr}, 8'h01);
        @(negedge clk);
        bus_sel = 0; #1;
        chk("R5 no pulse unselected", {7'h0, wdog_clr}, 8'h00);
        bus_wr = 0;
        read_stat(v);
        chk("R5 status unchanged", v, 8'h02);

        // Same cycle: write + read in the last low cycle before release
        apply(11'h001);
        repeat (HOLD - 1) @(negedge clk);
        chk("R8 still low at last cycle", {7'h0, sys_rst_n}, 8'h00);
        bus_sel = 1; bus_wr = 1; bus_rd = 1; #1;
        chk("R5 pulse at release cycle", {7'h0, wdog_clr}, 8'h01);
        chk("R1 old value at release cycle", bus_rdata, 8'h02);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_rd = 0;
        chk("R8 released", {7'h0, sys_rst_n}, 8'h01);
        read_stat(v);
        chk("R5 R2 transfer with write", v, 8'h40);

        // Random patterns
        prev = 8'h40;
        for (int i = 0; i < 60; i++) begin
            s = 11'($urandom & $urandom & $urandom & 32'h15B);
            s[2] = 1'($urandom); s[5] = 1'($urandom); s[7] = 1'($urandom);
            s[10] = ($urandom % 8) == 0;
            apply(s);
            chk("R8 random reset start", {7'h0, sys_rst_n}, {7'h0, ~exp_any(s)});
            if (exp_any(s)) begin
                wait_release(lows);
                chk("R8 random hold", 8'(lows), 8'(HOLD));
                prev = s[10] ? 8'h00 : exp_vec(s);
            end
            read_stat(v);
            chk("R2 R4 R6 R7 random result", v, prev);
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule